// File: doc/BRIEF.md
# Pipelined Banked Instruction ROM

This block is a 256-byte instruction store that the fetch side can only read. The store is arranged as eight rows of 32 bytes. A read presents an 8-bit byte address. The upper address bits pick a row and the middle bits pick one 32-bit word inside that row. The word comes back a fixed three cycles later. Two register stages split the row selection from the word selection, so a new address can be accepted on every cycle.

Before any fetches take place, a separate load port fills the store one 32-bit word per cycle. It uses a 6-bit word address. The load port is used only while no read requests are being issued. The store has no reset of its contents. Only the pipeline valid flags and the output word are cleared by reset.

Top module: `fetch_rom_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, `rd_valid_o` and `rd_data_o` are both 0 after that edge.
- R2: A request sampled with `rd_valid_i`=1 at rising edge N makes `rd_valid_o`=1 after edge N+2, which is three cycles after the address is presented. A cycle sampled with `rd_valid_i`=0 gives `rd_valid_o`=0 at the same position.
- R3: Requests issued on consecutive cycles return on consecutive cycles, in issue order, with no bubbles between them.
- R4: Byte address bits [7:5] select the row and bits [4:2] select the 32-bit word within the row. Together they form the word address {row, word}.
- R5: Byte address bits [1:0] have no effect on the returned word.
- R6: Little-endian packing: the byte at byte address 4w+k sits in bits [8k+7:8k] of word w, for k = 0..3.
- R7: When `ld_en_i` is high at a rising edge, `ld_data_i` is stored at word address `ld_waddr_i` (bits [5:3] row, bits [2:0] word within the row). All other words keep their contents.
- R8: While `rd_valid_o` is 0, `rd_data_o` keeps the last word that was returned.
- R9: `ld_en_i` and `rd_valid_i` are never high in the same cycle. Loads happen only while reads are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid_i | input | 1 | Read request this cycle |
| rd_addr_i | input | 8 | Byte address of the read |
| ld_en_i | input | 1 | Load one word this cycle |
| ld_waddr_i | input | 6 | Word address of the load |
| ld_data_i | input | 32 | Word to load |
| rd_valid_o | output | 1 | Returned word is valid |
| rd_data_o | output | 32 | Returned word |

## Verification
The assertions check three things on every cycle:
- `rd_valid_o` follows the request stream exactly three cycles later.
- The output word stays stable whenever no result is returned.
- Loads never coincide with a read request.

The reset state is also checked by a property. Whether the returned word is the right one can only be shown by the bench scenarios. These cover:
- correct row and word decode;
- ignoring of the two low address bits;
- little-endian byte packing;
- a reload of a single word leaving its neighbours untouched.

The bench sends each of these as back-to-back and gapped request streams and compares every returned word against its own byte model.

// File: rtl/irom_pkg.sv
package irom_pkg;
  // Default geometry of the instruction store.
  localparam int DEF_ADDR_W    = 8;   // byte address width
  localparam int DEF_ROW_BYTES = 32;  // bytes per row
  localparam int DEF_WORD_W    = 32;  // bits per returned word
endpackage

// File: rtl/irom_bank.sv
// One word lane of the store: holds one word of every row.
// Synchronous write and registered read, shaped for block RAM inference.
module irom_bank #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/irom_word_sel.sv
// Second cut: picks one word out of the registered row and registers it.
module irom_word_sel #(
  parameter int ROW_W  = 256,
  parameter int WORD_W = 32,
  localparam int NWORD = ROW_W / WORD_W,
  localparam int SW    = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [SW-1:0]     sel_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-1:0] picked;

  always_comb picked = row_i[sel_i*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= picked;
    end
  end
endmodule

// File: rtl/fetch_rom_pipe.sv
module fetch_rom_pipe #(
  parameter int ADDR_W    = irom_pkg::DEF_ADDR_W,
  parameter int ROW_BYTES = irom_pkg::DEF_ROW_BYTES,
  parameter int WORD_W    = irom_pkg::DEF_WORD_W
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 rd_valid_i,
  input  logic [ADDR_W-1:0]                    rd_addr_i,
  input  logic                                 ld_en_i,
  input  logic [ADDR_W-$clog2(WORD_W/8)-1:0]   ld_waddr_i,
  input  logic [WORD_W-1:0]                    ld_data_i,
  output logic                                 rd_valid_o,
  output logic [WORD_W-1:0]                    rd_data_o
);
  localparam int ROW_W      = ROW_BYTES * 8;
  localparam int NUM_ROWS   = (2 ** ADDR_W) / ROW_BYTES;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int NWORD      = ROW_W / WORD_W;
  localparam int BSEL_W     = $clog2(WORD_BYTES);
  localparam int WSEL_W     = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam int RSEL_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;

  // Byte-within-word bits are not used by a word-aligned fetch.
  logic unused_byte_bits;
  assign unused_byte_bits = ^rd_addr_i[BSEL_W-1:0];

  // Stage 0: capture the request.
  logic              s0_valid;
  logic [RSEL_W-1:0] s0_row;
  logic [WSEL_W-1:0] s0_wsel;

  always_ff @(posedge clk) begin
    if (rst) s0_valid <= 1'b0;
    else     s0_valid <= rd_valid_i;
  end

  always_ff @(posedge clk) begin
    s0_row  <= rd_addr_i[BSEL_W+WSEL_W +: RSEL_W];
    s0_wsel <= rd_addr_i[BSEL_W +: WSEL_W];
  end

  // Stage 1: registered row read from all word lanes, plus word select.
  logic              s1_valid;
  logic [WSEL_W-1:0] s1_wsel;
  logic [ROW_W-1:0]  s1_row;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= s0_valid;
  end

  always_ff @(posedge clk) begin
    if (s0_valid) s1_wsel <= s0_wsel;
  end

  for (genvar g = 0; g < NWORD; g++) begin : g_lane
    logic lane_we;
    assign lane_we = ld_en_i && (ld_waddr_i[WSEL_W-1:0] == WSEL_W'(g));

    irom_bank #(
      .DEPTH (NUM_ROWS),
      .WIDTH (WORD_W)
    ) u_bank (
      .clk   (clk),
      .we    (lane_we),
      .waddr (ld_waddr_i[WSEL_W +: RSEL_W]),
      .wdata (ld_data_i),
      .re    (s0_valid),
      .raddr (s0_row),
      .rdata (s1_row[g*WORD_W +: WORD_W])
    );
  end

  // Stage 2: word select into the output register.
  irom_word_sel #(
    .ROW_W  (ROW_W),
    .WORD_W (WORD_W)
  ) u_wsel (
    .clk     (clk),
    .rst     (rst),
    .valid_i (s1_valid),
    .sel_i   (s1_wsel),
    .row_i   (s1_row),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/fetch_rom_pipe_chk.sv
module fetch_rom_pipe_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_valid_i,
  input logic              ld_en_i,
  input logic              rd_valid_o,
  input logic [WORD_W-1:0] rd_data_o
);
  // Shadow of the request stream, three cycles deep.
  logic p1, p2, p3;
  always_ff @(posedge clk) begin
    if (rst) begin
      p1 <= 1'b0; p2 <= 1'b0; p3 <= 1'b0;
    end else begin
      p1 <= rd_valid_i; p2 <= p1; p3 <= p2;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!rd_valid_o && rd_data_o == '0)); // R1

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o == p3); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> $stable(rd_data_o)); // R8

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    ld_en_i |-> !rd_valid_i); // R9
endmodule

bind fetch_rom_pipe fetch_rom_pipe_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_valid_i (rd_valid_i),
  .ld_en_i    (ld_en_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/fetch_rom_pipe_bench.sv
`timescale 1ns/1ps
module fetch_rom_pipe_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_valid_i = 1'b0;
  logic [7:0]  rd_addr_i = '0;
  logic        ld_en_i = 1'b0;
  logic [5:0]  ld_waddr_i = '0;
  logic [31:0] ld_data_i = '0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;

  always #4 clk = ~clk; // 125 MHz

  fetch_rom_pipe u_fetch_rom_pipe (
    .clk(clk), .rst(rst), .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i),
    .ld_en_i(ld_en_i), .ld_waddr_i(ld_waddr_i), .ld_data_i(ld_data_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  typedef struct {
    logic [31:0] data;
    int          arrival;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  bytes_m [256];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] last_data = '0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // R6: little-endian assembly from the byte model.
  function automatic logic [31:0] exp_word(input logic [7:0] a);
    logic [7:0] b;
    b = {a[7:2], 2'b00};
    return {bytes_m[b + 8'd3], bytes_m[b + 8'd2], bytes_m[b + 8'd1], bytes_m[b]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_word(input int w, input logic [31:0] d); // R7
    ld_en_i = 1'b1; ld_waddr_i = 6'(w); ld_data_i = d;
    for (int k = 0; k < 4; k++) bytes_m[4*w + k] = d[8*k +: 8];
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic issue(input logic [7:0] a, input string tag);
    exp_t e;
    rd_valid_i = 1'b1; rd_addr_i = a;
    e.data = exp_word(a); e.arrival = cyc + 3; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    rd_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares returned words and their arrival cycle.
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid_o) begin
        if (sb.size() == 0) begin
          check("R2 unexpected valid", 32'(rd_valid_o), 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " data"}, rd_data_o, e.data);
          check("R2 arrival cycle", 32'(cyc), 32'(e.arrival));
          last_data = rd_data_o;
        end
      end else if (sb.size() != 0 && sb[0].arrival <= cyc) begin
        check("R2 missing result", 32'(rd_valid_o), 32'd1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(rd_valid_o), 32'd0);
    check("R1 data in reset", rd_data_o, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // Fill: byte at address i holds i^0x5A, packed little-endian (R6, R7).
    for (int w = 0; w < 64; w++) begin
      logic [31:0] d;
      for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'(4*w + k) ^ 8'h5A;
      load_word(w, d);
    end
    check("R1 idle after reset", 32'(rd_valid_o), 32'd0);

    // R3/R4: every word, back to back.
    for (int w = 0; w < 64; w++) issue(8'(4*w), "R3 R4 sweep");
    drain();

    // R6: one explicit lane check.
    issue(8'h24, "R6 endian");
    drain();
    check("R6 byte0 in [7:0]", 32'(last_data[7:0]), 32'(8'h24 ^ 8'h5A));
    check("R6 byte3 in [31:24]", 32'(last_data[31:24]), 32'(8'h27 ^ 8'h5A));

    // R5: low bits ignored.
    for (int k = 0; k < 4; k++) issue(8'hB0 | 8'(k), "R5 low bits");
    drain();

    // R2: gapped and scrambled stream.
    for (int i = 0; i < 20; i++) begin
      issue(8'(i * 37 + 3), "R2 gapped");
      repeat (i % 3) @(negedge clk);
    end
    drain();

    // R8: output holds while idle.
    repeat (5) @(negedge clk);
    check("R8 valid low when idle", 32'(rd_valid_o), 32'd0);
    check("R8 data held", rd_data_o, last_data);

    // R7: reload one word, neighbours unchanged (R4 row/word decode).
    load_word(6'd42, 32'hDEAD_BEEF);
    issue(8'(4*41), "R7 neighbour below");
    issue(8'(4*42), "R7 reloaded word");
    issue(8'(4*43), "R7 neighbour above");
    issue(8'(4*34), "R7 same lane other row");
    drain();
    check("R7 reloaded value", exp_word(8'(4*42)), 32'hDEAD_BEEF);

    // R4: rows in reverse order, word 7 of each.
    for (int r = 7; r >= 0; r--) issue(8'(r*32 + 28), "R4 reverse rows");
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule